// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block is a synchronous master for a 128-word by 16-bit serial EEPROM that uses a three-wire select/clock/data-in link plus a separate data-out line. A host hands it one word request at a time over a valid/ready handshake. The request carries a write flag, a 7-bit word address and, for writes, 16 bits of data. The controller serialises the command, generates the serial clock by dividing the system clock, and returns read data with a one-cycle valid strobe.

After reset the controller issues a single write-enable command on its own, and only then accepts host traffic. After every write it drops select for a programmable minimum time. It then raises select again with the data-in line held low and no clock, and watches the device's data-out level. Low means the internal write is still running. High means the device is ready. If ready does not appear within a programmable number of cycles, the controller stops polling and raises a sticky timeout flag. No new command is accepted while a write or its poll is in progress.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: While reset is held, `eep_cs_o`, `eep_sk_o`, `eep_di_o`, `req_ready_o`, `rd_valid_o` and `busy_timeout_o` are all 0. After reset, before `req_ready_o` first rises, exactly one 10-bit enable frame is sent. Its bits are, in send order, 1, 0, 0, 1, 1 followed by five 0s.
- R2: The serial clock is low whenever select is low. Each high phase lasts exactly `SK_HALF_CYC` system cycles. Data-in changes only when the serial clock falls or while it is low, never during a high phase.
- R3: A read sends 1, 1, 0 and then the address, most significant bit first. It gives 26 rising clock edges in one select window.
- R4: On a read, the bit seen on data-out at the 10th rising edge (the dummy 0) is discarded. The next 16 rising edges capture D15 down to D0. When select falls, `rd_valid_o` pulses high for one cycle with that word on `rd_data_o`.
- R5: A write sends 1, 0, 1, then the address and then the data, each most significant bit first. It gives 26 rising edges in one select window.
- R6: Select stays low for at least `CS_GAP_CYC` system cycles before every rising edge of select. This covers the gap between a write frame and its status poll.
- R7: During a status poll, select is high, the serial clock is low and data-in is low. A low level on data-out keeps the poll going, and a high level ends it.
- R8: `req_ready_o` is low whenever select is high, and for the whole time the device reports busy after a write.
- R9: If data-out stays low for `POLL_LIMIT_CYC` poll cycles, the controller drops select and sets `busy_timeout_o`. The flag stays set until the next request is accepted.
- R10: Data-out is ignored outside the read-data and poll phases. Any level there leaves read results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Word address |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | One-cycle strobe: read word available |
| rd_data_o | output | 16 | Read word |
| busy_timeout_o | output | 1 | Sticky: last write poll expired |
| eep_cs_o | output | 1 | Device select |
| eep_sk_o | output | 1 | Serial clock |
| eep_di_o | output | 1 | Serial data to device |
| eep_do_i | input | 1 | Serial data / status from device |

## Verification
The bench pairs the controller with a behavioural device that drives the dummy 0, holds its busy level for a settable time, and ignores frames begun while busy. Words with both D15 and D0 set are read back. A controller that kept the dummy bit would return such a word shifted by one place, losing D0. A stretched busy time drives the poll past its limit. A design that never timed out would hang, and one that did not clear the flag on the next accepted request would report a stale error. A toggling level on data-out is applied outside the driven phases, so a design that sampled it there would corrupt read data. Monitors measure the select gap, the clock high phase and data-in during polls.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 2;
  localparam int CMD_W   = 1 + OP_W + ADDR_W;   // start + opcode + address
  localparam int FRAME_W = CMD_W + DATA_W;      // longest frame
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [OP_W-1:0] OP_RD  = 2'b10;
  localparam logic [OP_W-1:0] OP_WR  = 2'b01;
  localparam logic [OP_W-1:0] OP_EXT = 2'b00;

  typedef enum logic [1:0] {K_EWEN, K_READ, K_WRITE} cmd_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} phase_e;

  // Frame left-justified: bit FRAME_W-1 goes out first.
  function automatic logic [FRAME_W-1:0] build_frame(cmd_kind_e k,
                                                     logic [ADDR_W-1:0] a,
                                                     logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] f;
    case (k)
      K_READ:  f = {1'b1, OP_RD, a, {DATA_W{1'b0}}};
      K_WRITE: f = {1'b1, OP_WR, a, d};
      default: f = {1'b1, OP_EXT, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    endcase
    return f;
  endfunction

  // Number of rising serial-clock edges in a frame of this kind.
  function automatic logic [CNT_W-1:0] frame_rises(cmd_kind_e k);
    return (k == K_EWEN) ? CNT_W'(CMD_W) : CNT_W'(FRAME_W);
  endfunction

  // Zero-based rise index at which a read captures a data bit.
  function automatic logic capture_rise(cmd_kind_e k, logic [CNT_W-1:0] idx);
    return (k == K_READ) && (idx >= CNT_W'(CMD_W));
  endfunction
endpackage

// File: rtl/uwire_sk_gen.sv
module uwire_sk_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  logic [HW-1:0] cnt;
  logic term;

  assign term     = en && (cnt == HW'(HALF_CYC - 1));
  assign rise_evt = term && !sk;
  assign fall_evt = term && sk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      sk  <= ~sk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
  a_r2_no_clock_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !sk);
endmodule

// File: rtl/uwire_wait_timer.sv
module uwire_wait_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/uwire_shift_unit.sv
module uwire_shift_unit
  import uwire_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               shift_en,
  input  logic               cap_en,
  input  logic               cap_bit,
  output logic               next_bit,
  output logic [DATA_W-1:0]  cap_word
);
  logic [FRAME_W-1:0] shreg;

  assign next_bit = shreg[FRAME_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cap_word <= '0;
    end else begin
      if (load)          shreg <= load_val;
      else if (shift_en) shreg <= {shreg[FRAME_W-2:0], 1'b0};
      if (cap_en)        cap_word <= {cap_word[DATA_W-2:0], cap_bit};
    end
  end

  a_r4_no_capture_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && cap_en));
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwire_pkg::*;
#(
  parameter int SK_HALF_CYC    = 4,
  parameter int CS_GAP_CYC     = 10,
  parameter int POLL_LIMIT_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_timeout_o,
  output logic              eep_cs_o,
  output logic              eep_sk_o,
  output logic              eep_di_o,
  input  logic              eep_do_i
);
  phase_e            state;
  cmd_kind_e         kind;
  logic [CNT_W-1:0]  rise_idx;
  logic              tail, init_done, poll_pend;
  logic              cs_q, di_q;

  // Named internal events
  logic in_shift, in_gap, in_poll;
  logic rise_evt, fall_evt, gap_done, poll_expired;
  logic accept, start_frame, frame_end, last_rise, cap_now;
  logic poll_ready, poll_fail, next_bit;
  cmd_kind_e          next_kind;
  logic [FRAME_W-1:0] load_val;
  logic [DATA_W-1:0]  cap_word;

  assign in_shift = (state == S_SHIFT);
  assign in_gap   = (state == S_GAP);
  assign in_poll  = (state == S_POLL);

  assign req_ready_o = (state == S_IDLE) && init_done;
  assign accept      = req_valid_i && req_ready_o;
  assign next_kind   = !init_done ? K_EWEN : (req_write_i ? K_WRITE : K_READ);
  assign load_val    = build_frame(next_kind, req_addr_i, req_wdata_i);
  assign start_frame = accept || (in_gap && gap_done && !poll_pend && !init_done);

  assign last_rise  = in_shift && rise_evt && (rise_idx == frame_rises(kind) - 1'b1);
  assign frame_end  = in_shift && fall_evt && tail;
  assign cap_now    = in_shift && rise_evt && capture_rise(kind, rise_idx);
  assign poll_ready = in_poll && eep_do_i;
  assign poll_fail  = in_poll && !eep_do_i && poll_expired;

  assign eep_cs_o = cs_q;
  assign eep_di_o = di_q;

  uwire_sk_gen #(.HALF_CYC(SK_HALF_CYC)) sk_gen_i (
    .clk(clk), .rst_n(rst_n), .en(in_shift),
    .sk(eep_sk_o), .rise_evt(rise_evt), .fall_evt(fall_evt));

  uwire_wait_timer #(.LIMIT(CS_GAP_CYC)) gap_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(in_gap), .done(gap_done));

  uwire_wait_timer #(.LIMIT(POLL_LIMIT_CYC)) poll_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(in_poll), .done(poll_expired));

  uwire_shift_unit shift_i (
    .clk(clk), .rst_n(rst_n), .load(start_frame), .load_val(load_val),
    .shift_en(in_shift && fall_evt), .cap_en(cap_now), .cap_bit(eep_do_i),
    .next_bit(next_bit), .cap_word(cap_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_GAP;
      kind           <= K_EWEN;
      rise_idx       <= '0;
      tail           <= 1'b0;
      init_done      <= 1'b0;
      poll_pend      <= 1'b0;
      cs_q           <= 1'b0;
      rd_valid_o     <= 1'b0;
      rd_data_o      <= '0;
      busy_timeout_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      if (start_frame) begin
        state    <= S_SHIFT;
        kind     <= next_kind;
        rise_idx <= '0;
        tail     <= 1'b0;
        cs_q     <= 1'b1;
        if (accept) busy_timeout_o <= 1'b0;
      end else begin
        case (state)
          S_SHIFT: begin
            if (rise_evt) rise_idx <= rise_idx + 1'b1;
            if (last_rise) tail <= 1'b1;
            if (frame_end) begin
              state     <= S_GAP;
              cs_q      <= 1'b0;
              poll_pend <= (kind == K_WRITE);
              if (kind == K_EWEN) init_done <= 1'b1;
              if (kind == K_READ) begin
                rd_valid_o <= 1'b1;
                rd_data_o  <= cap_word;
              end
            end
          end
          S_GAP: begin
            if (gap_done) begin
              if (poll_pend) begin
                state <= S_POLL;
                cs_q  <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_POLL: begin
            if (poll_ready || poll_fail) begin
              state     <= S_GAP;
              cs_q      <= 1'b0;
              poll_pend <= 1'b0;
            end
            if (poll_fail) busy_timeout_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           di_q <= 1'b0;
    else if (start_frame)                 di_q <= load_val[FRAME_W-1];
    else if (in_shift && fall_evt && !tail) di_q <= next_bit;
    else if (frame_end || !in_shift)      di_q <= 1'b0;
  end

  // ---------------- assertions ----------------
  localparam int GW = $clog2(CS_GAP_CYC + 2);
  logic [GW-1:0]    cs_low_run;
  logic [CNT_W-1:0] sk_rise_run;
  logic             sk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_low_run  <= '0;
      sk_rise_run <= '0;
      sk_prev     <= 1'b0;
    end else begin
      sk_prev <= eep_sk_o;
      if (eep_cs_o) cs_low_run <= '0;
      else if (cs_low_run < GW'(CS_GAP_CYC)) cs_low_run <= cs_low_run + 1'b1;
      if (!eep_cs_o) sk_rise_run <= '0;
      else if (eep_sk_o && !sk_prev) sk_rise_run <= sk_rise_run + 1'b1;
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready_o && !rd_valid_o);
  a_r2_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    eep_sk_o |-> eep_cs_o);
  a_r2_di_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    eep_sk_o && $past(eep_sk_o) |-> $stable(eep_di_o));
  a_r3_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eep_cs_o) |-> (sk_rise_run == '0) || (sk_rise_run == CNT_W'(CMD_W))
                        || (sk_rise_run == CNT_W'(FRAME_W)));
  a_r4_rd_valid_at_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $fell(eep_cs_o));
  a_r6_cs_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eep_cs_o) |-> cs_low_run >= GW'(CS_GAP_CYC));
  a_r7_poll_lines: assert property (@(posedge clk) disable iff (!rst_n)
    in_poll |-> eep_cs_o && !eep_di_o && !eep_sk_o);
  a_r8_cs_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eep_cs_o |-> !req_ready_o);
  a_r9_timeout_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_timeout_o) |-> $past(in_poll) && !$past(eep_do_i));
endmodule

// File: tb/uwire_eeprom_ctrl_tb.sv
module uwire_eeprom_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SK_HALF    = 2;
  localparam int CS_GAP     = 5;
  localparam int POLL_LIM   = 400;

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 7'h00, 16'hA5C3}, '{1'b0, 7'h00, 16'h0000},
    '{1'b1, 7'h7F, 16'h8001}, '{1'b0, 7'h7F, 16'h0000},
    '{1'b1, 7'h55, 16'h0000}, '{1'b0, 7'h55, 16'h0000},
    '{1'b0, 7'h2A, 16'h0000}, '{1'b1, 7'h01, 16'hFFFF},
    '{1'b0, 7'h01, 16'h0000}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, busy_timeout, cs, sk, di;
  logic [15:0] rd_data;
  logic eep_do;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------- behavioural device ----------
  logic [15:0] mem [128];
  logic [15:0] ref_mem [128];
  logic [25:0] rx, last_rx;
  int bitcnt = 0, last_cnt = 0, busy_left = 0, busy_cyc = 60, ewen_seen = 0;
  logic wen = 0, status_mode = 0, frame_dead = 0, op_read = 0;
  logic drv_en = 0, do_drv = 1, noise_en = 0, noise_bit = 0;
  logic sk_p = 0, cs_p = 0;
  logic [6:0] raddr = '0;

  function automatic logic [15:0] seed_word(int a);
    logic [6:0] x = 7'(a);
    return {x, ~x, 2'b01};
  endfunction

  assign eep_do = (cs && status_mode) ? (busy_left == 0) :
                  drv_en ? do_drv : (noise_en ? noise_bit : 1'b1);

  always @(negedge clk) begin
    if (busy_left > 0) busy_left--;
    noise_bit <= ~noise_bit;
    if (!cs) begin
      if (cs_p && !frame_dead && bitcnt > 0) begin
        last_rx = rx; last_cnt = bitcnt;
        if (bitcnt == 26 && rx[25:23] == 3'b101 && wen) begin
          mem[rx[22:16]] = rx[15:0];
          busy_left = busy_cyc;
          status_mode = 1;
        end
        if (bitcnt == 10 && rx[9:5] == 5'b10011) begin
          wen = 1; ewen_seen++;
        end
      end
      bitcnt = 0; rx = '0; drv_en = 0; op_read = 0;
    end else begin
      if (!cs_p) frame_dead = (busy_left > 0);
      if (sk && !sk_p) begin
        rx = {rx[24:0], di}; bitcnt++; status_mode = 0;
        if (bitcnt == 3 && rx[2:0] == 3'b110) op_read = 1;
      end
      if (!sk && sk_p && op_read && !frame_dead) begin
        if (bitcnt == 9) begin drv_en = 1; do_drv = 0; end
        else if (bitcnt >= 10 && bitcnt <= 25) begin
          if (bitcnt == 10) raddr = rx[6:0];
          do_drv = mem[raddr][25-bitcnt];
        end else if (bitcnt >= 26) drv_en = 0;
      end
    end
    cs_p = cs; sk_p = sk;
  end

  // ---------- line monitors ----------
  int hi_run = 0, sk_bad = 0, sk_highs = 0, di_bad = 0, low_run = 0, min_gap = 1000;
  int poll_di_bad = 0, poll_seen = 0, ready_busy = 0;
  logic msk = 0, mdi = 0, mcs = 0, tmo_mode = 0;
  always @(negedge clk) if (rst_n) begin
    if (sk != msk) begin
      if (msk && hi_run != SK_HALF) sk_bad++;
      if (sk) sk_highs++;
      hi_run = 1;
    end else hi_run++;
    if (sk && msk && di != mdi) di_bad++;
    if (!cs) low_run++;
    else if (!mcs) begin
      if (low_run < min_gap) min_gap = low_run;
      low_run = 0;
    end
    if (cs && status_mode && busy_left > 0) begin
      poll_seen++;
      if (di || sk) poll_di_bad++;
    end
    if (req_ready && busy_left > 0 && !tmo_mode) ready_busy++;
    msk = sk; mdi = di; mcs = cs;
  end

  uwire_eeprom_ctrl #(.SK_HALF_CYC(SK_HALF), .CS_GAP_CYC(CS_GAP),
                      .POLL_LIMIT_CYC(POLL_LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_timeout_o(busy_timeout),
    .eep_cs_o(cs), .eep_sk_o(sk), .eep_di_o(di), .eep_do_i(eep_do));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic wr, logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(logic [6:0] a, logic [15:0] d);
    issue(1'b1, a, d);
    ref_mem[a] = d;
    while (!req_ready) @(negedge clk);
    check("R5 write frame", {6'd0, last_rx}, {6'd0, 3'b101, a, d});
  endtask

  task automatic do_read(logic [6:0] a, string req);
    issue(1'b0, a, 16'h0);
    while (!rd_valid) @(negedge clk);
    check(req, {16'd0, rd_data}, {16'd0, ref_mem[a]});
    @(negedge clk);
    check("R4 rd_valid one cycle", {31'd0, rd_valid}, 32'd0);
    check("R3 read frame", {6'd0, last_rx[25:16], 16'd0}, {6'd0, 3'b110, a, 16'd0});
  endtask

  initial begin
    for (int i = 0; i < POLL_LIM * 200; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin mem[i] = seed_word(i); ref_mem[i] = seed_word(i); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset lines", {26'd0, cs, sk, di, req_ready, rd_valid, busy_timeout}, 32'd0);
    rst_n = 1;
    while (!req_ready) @(negedge clk);
    check("R1 single enable frame", ewen_seen, 1);
    check("R1 enable frame length", last_cnt, 10);

    for (int v = 0; v < 9; v++) begin
      if (VECS[v].wr) do_write(VECS[v].addr, VECS[v].data);
      else do_read(VECS[v].addr, "R4 read data");
    end
    check("R3 read frame rises", last_cnt, 26);

    // R10: toggling data-out outside driven phases
    noise_en = 1;
    do_write(7'h33, 16'h6C39);
    do_read(7'h33, "R10 read under noise");
    do_read(7'h2B, "R10 untouched word under noise");
    noise_en = 0;

    // R9: busy longer than the poll limit
    tmo_mode = 1; busy_cyc = POLL_LIM + 300;
    issue(1'b1, 7'h44, 16'h1234);
    ref_mem[7'h44] = 16'h1234;
    while (!req_ready) @(negedge clk);
    check("R9 timeout flag set", {31'd0, busy_timeout}, 32'd1);
    check("R9 select dropped", {31'd0, cs}, 32'd0);
    repeat (10) @(negedge clk);
    check("R9 flag sticky", {31'd0, busy_timeout}, 32'd1);
    while (busy_left > 0) @(negedge clk);
    tmo_mode = 0; busy_cyc = 60;
    do_read(7'h44, "R9 read after timeout");
    check("R9 flag cleared on accept", {31'd0, busy_timeout}, 32'd0);

    // line monitors
    check("R2 high phase length", sk_bad, 0);
    check("R2 clock ran", {31'd0, sk_highs > 0}, 32'd1);
    check("R2 data-in steady while high", di_bad, 0);
    check("R6 minimum select gap", {31'd0, min_gap >= CS_GAP}, 32'd1);
    check("R7 poll observed", {31'd0, poll_seen > 0}, 32'd1);
    check("R7 data-in and clock low in poll", poll_di_bad, 0);
    check("R8 no ready while busy", ready_busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule